// File: doc/BRIEF.md
# Interrupt Routing Mode Autodetector

This block sits beside the configuration path of a PCI-style host bridge and watches configuration writes as they go past. System software announces, through the value it writes into each function's interrupt-line register, which interrupt routing it believes the board uses. The block compares that value against the numbers that older, incorrect software would have written for the slot concerned. From that comparison it settles once, and for good, on either the legacy (incorrect) routing or the correct one. The interrupt router downstream reads the resulting 2-bit mode.

Until such a telling write arrives, the block stays in a provisional "assume correct" state. A reset preset lets the integrator force either final verdict from the start. A board-variant input turns detection off altogether, for the board that never had the legacy problem. The block only observes traffic. It never stalls or alters the configuration write, which the surrounding bus logic forwards unchanged. Its write strobe therefore has no ready signal and no back-pressure: every cycle in which the strobe is high is one observed write.

Top module: `irq_map_detect`

## Requirements
- R1: Under synchronous reset, the mode loads from the preset input with the encoding 0 = assume-ok, 1 = legacy (broken), 2 = correct (force-ok). A preset of 3 loads assume-ok. The preset has no effect outside reset.
- R2: Once the mode is 1 or 2, it keeps that value until the next reset, whatever writes follow.
- R3: A write is examined only if the strobe is high, the low address byte [7:0] equals 0x3C and the variant input is low. Any other cycle leaves the mode unchanged.
- R4: The slot number is address bits [15:11], and classification uses that slot modulo 4, which is bits [12:11]. The function bits [10:8] and address bits [23:16] do not affect the decision.
- R5: A written value of 27 leaves the mode at 0 when the slot modulo 4 is 2. In any other slot it sets the mode to 1.
- R6: A written value equal to 27 plus the slot modulo 4, or to 91 plus the slot modulo 4, sets the mode to 1.
- R7: Any other value in an examined write sets the mode to 2.
- R8: The decision is taken at the rising edge where the strobe is sampled high. The new mode appears after that edge, and the mode is unchanged before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| preset_mode | input | 2 | Mode loaded during reset (3 loads assume-ok) |
| alt_variant | input | 1 | High disables detection (board variant without the legacy issue) |
| cfg_wr_valid | input | 1 | One configuration write is present this cycle |
| cfg_addr | input | 24 | Configuration address: [15:11] slot, [10:8] function, [7:0] register offset |
| cfg_wdata | input | 8 | Byte written to the addressed register |
| map_mode | output | 2 | Current routing mode: 0 assume-ok, 1 legacy, 2 correct |

## Verification
Every result of this block is due one clock after its cause. A reset takes effect at the edge where reset is sampled, and a qualified write at the edge where its strobe is sampled high. The bench changes inputs on falling edges and reads the mode on the next falling edge, half a period after the edge that must have updated it. For R8 the bench also reads the mode a few nanoseconds after driving a write, before the rising edge, and expects the old value there. Tests of ignored writes and locked states read the mode in the cycle after the write, before any other stimulus.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;

  typedef enum logic [1:0] {
    MAP_ASSUME_OK = 2'd0,
    MAP_BROKEN    = 2'd1,
    MAP_FORCE_OK  = 2'd2
  } map_mode_e;

  function automatic map_mode_e sanitize_preset(input logic [1:0] raw);
    case (raw)
      2'd1:    return MAP_BROKEN;
      2'd2:    return MAP_FORCE_OK;
      default: return MAP_ASSUME_OK;
    endcase
  endfunction

endpackage

// File: rtl/cfg_snoop_decode.sv
module cfg_snoop_decode #(
  parameter int ADDR_W    = 24,
  parameter int DEVFN_LSB = 8,
  parameter int FUNC_W    = 3,
  parameter int NUM_PINS  = 4,
  parameter int LINE_OFF  = 8'h3C
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_valid,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        alt_variant,
  output logic                        hit,
  output logic [$clog2(NUM_PINS)-1:0] slot_mod
);
  localparam int PIN_W    = $clog2(NUM_PINS);
  localparam int SLOT_LSB = DEVFN_LSB + FUNC_W;

  logic [DEVFN_LSB-1:0] reg_off;

  assign reg_off  = addr[DEVFN_LSB-1:0];
  assign slot_mod = addr[SLOT_LSB +: PIN_W];
  assign hit      = wr_valid && !alt_variant && (reg_off == DEVFN_LSB'(LINE_OFF));

  // A qualified write must carry a fully defined address.
  AST_ADDR_DEFINED: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !$isunknown(addr)) else $error("address unknown"); // R4

endmodule

// File: rtl/irq_line_classifier.sv
module irq_line_classifier
  import irq_map_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PIN_W       = 2,
  parameter int IRQ_BASE    = 27,
  parameter int IRQ_ALT_ADD = 64,
  parameter int SHARED_SLOT = 2
) (
  input  logic [DATA_W-1:0] line_val,
  input  logic [PIN_W-1:0]  slot_mod,
  output map_mode_e         verdict
);
  localparam int EW = DATA_W + 1;
  localparam logic [EW-1:0] BASE_E = EW'(IRQ_BASE);
  localparam logic [EW-1:0] ALT_E  = EW'(IRQ_BASE + IRQ_ALT_ADD);

  logic [EW-1:0] val_e, slot_e, swz_plain, swz_alt;
  logic          is_base, is_swz;

  assign val_e     = {1'b0, line_val};
  assign slot_e    = EW'(slot_mod);
  assign swz_plain = BASE_E + slot_e;
  assign swz_alt   = ALT_E + slot_e;
  assign is_base   = (val_e == BASE_E);
  assign is_swz    = (val_e == swz_plain) || (val_e == swz_alt);

  always_comb begin
    if (is_base) begin
      verdict = (slot_mod == PIN_W'(SHARED_SLOT)) ? MAP_ASSUME_OK : MAP_BROKEN;
    end else if (is_swz) begin
      verdict = MAP_BROKEN;
    end else begin
      verdict = MAP_FORCE_OK;
    end
  end

endmodule

// File: rtl/map_mode_fsm.sv
module map_mode_fsm
  import irq_map_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] preset_mode,
  input  logic       hit,
  input  map_mode_e  verdict,
  output map_mode_e  state_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= sanitize_preset(preset_mode);
    end else if (hit && state_q == MAP_ASSUME_OK) begin
      state_q <= verdict;
    end
  end

  AST_PRESET3_LOADS_ASSUME: assert property (@(posedge clk)
    (rst && preset_mode == 2'd3) |=> state_q == MAP_ASSUME_OK) else $error("preset 3"); // R1

  AST_FINAL_IS_STICKY: assert property (@(posedge clk) disable iff (rst)
    state_q != MAP_ASSUME_OK |=> $stable(state_q)) else $error("left final state"); // R2

  AST_QUIET_WITHOUT_HIT: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(state_q)) else $error("changed without write"); // R3

  AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
    state_q != 2'd3) else $error("illegal mode"); // R1

endmodule

// File: rtl/irq_map_detect.sv
module irq_map_detect
  import irq_map_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int NUM_PINS    = 4,
  parameter int IRQ_BASE    = 27,
  parameter int IRQ_ALT_ADD = 64,
  parameter int SHARED_SLOT = 2,
  parameter int LINE_OFF    = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        preset_mode,
  input  logic              alt_variant,
  input  logic              cfg_wr_valid,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [1:0]        map_mode
);
  localparam int PIN_W = $clog2(NUM_PINS);

  logic             hit;
  logic [PIN_W-1:0] slot_mod;
  map_mode_e        verdict;
  map_mode_e        state_q;

  cfg_snoop_decode #(
    .ADDR_W(ADDR_W), .DEVFN_LSB(8), .FUNC_W(3), .NUM_PINS(NUM_PINS), .LINE_OFF(LINE_OFF)
  ) u_decode (
    .clk(clk), .rst(rst), .wr_valid(cfg_wr_valid), .addr(cfg_addr),
    .alt_variant(alt_variant), .hit(hit), .slot_mod(slot_mod)
  );

  irq_line_classifier #(
    .DATA_W(DATA_W), .PIN_W(PIN_W), .IRQ_BASE(IRQ_BASE),
    .IRQ_ALT_ADD(IRQ_ALT_ADD), .SHARED_SLOT(SHARED_SLOT)
  ) u_classify (
    .line_val(cfg_wdata), .slot_mod(slot_mod), .verdict(verdict)
  );

  map_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .preset_mode(preset_mode),
    .hit(hit), .verdict(verdict), .state_q(state_q)
  );

  assign map_mode = state_q;

  AST_SHARED_SLOT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (hit && map_mode == 2'd0 && cfg_wdata == DATA_W'(IRQ_BASE) && cfg_addr[12:11] == 2'd2)
    |=> map_mode == 2'd0) else $error("shared slot moved"); // R5

  AST_BASE_ELSEWHERE_BROKEN: assert property (@(posedge clk) disable iff (rst)
    (hit && map_mode == 2'd0 && cfg_wdata == DATA_W'(IRQ_BASE) && cfg_addr[12:11] != 2'd2)
    |=> map_mode == 2'd1) else $error("27 not broken"); // R5

  AST_SWIZZLE_BROKEN: assert property (@(posedge clk) disable iff (rst)
    (hit && map_mode == 2'd0 &&
     (cfg_wdata == DATA_W'(IRQ_BASE) + DATA_W'(cfg_addr[12:11]) ||
      cfg_wdata == DATA_W'(IRQ_BASE + IRQ_ALT_ADD) + DATA_W'(cfg_addr[12:11])))
    |=> map_mode == 2'd1) else $error("swizzle not broken"); // R6

  AST_ALT_VARIANT_IDLE: assert property (@(posedge clk) disable iff (rst)
    alt_variant |=> $stable(map_mode)) else $error("variant detected"); // R3

endmodule

// File: tb/irq_map_detect_bench.sv
`timescale 1ns/1ps
module irq_map_detect_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  preset_mode = 2'd0;
  logic        alt_variant = 1'b0;
  logic        cfg_wr_valid = 1'b0;
  logic [23:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [1:0]  map_mode;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_map_detect u_irq_map_detect (
    .clk(clk), .rst(rst), .preset_mode(preset_mode), .alt_variant(alt_variant),
    .cfg_wr_valid(cfg_wr_valid), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .map_mode(map_mode)
  );

  task automatic check(input string req, input logic [1:0] exp);
    n_chk++;
    if (map_mode !== exp) begin
      n_err++;
      $display("FAIL %s: map_mode=%0d expected=%0d", req, map_mode, exp);
    end
  endtask

  task automatic apply_reset(input logic [1:0] p);
    @(negedge clk);
    preset_mode = p; rst = 1'b1; cfg_wr_valid = 1'b0; alt_variant = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Drives one write for a cycle; on return the mode reflects it.
  task automatic cfg_write(input int slot, input int func, input logic [7:0] off,
                           input logic [7:0] d, input logic alt);
    @(negedge clk);
    cfg_wr_valid = 1'b1; alt_variant = alt; cfg_wdata = d;
    cfg_addr = {8'hA5, 5'(slot), 3'(func), off};
    @(negedge clk);
    cfg_wr_valid = 1'b0; alt_variant = 1'b0;
  endtask

  task automatic t_presets;
    apply_reset(2'd0); check("R1 preset 0", 2'd0);
    apply_reset(2'd1); check("R1 preset 1", 2'd1);
    apply_reset(2'd2); check("R1 preset 2", 2'd2);
    apply_reset(2'd3); check("R1 preset 3", 2'd0);
    preset_mode = 2'd2;
    @(negedge clk); @(negedge clk);
    check("R1 preset ignored outside reset", 2'd0);
  endtask

  task automatic t_qualify;
    apply_reset(2'd0);
    cfg_write(1, 0, 8'h3C, 8'd27, 1'b1); check("R3 variant high ignored", 2'd0);
    cfg_write(1, 0, 8'h3D, 8'd27, 1'b0); check("R3 wrong offset ignored", 2'd0);
    cfg_write(1, 0, 8'h00, 8'd99, 1'b0); check("R3 offset 0 ignored", 2'd0);
    @(negedge clk);
    cfg_addr = {8'h00, 5'd1, 3'd0, 8'h3C}; cfg_wdata = 8'd27; cfg_wr_valid = 1'b0;
    @(negedge clk);
    check("R3 strobe low ignored", 2'd0);
  endtask

  task automatic t_base_value;
    apply_reset(2'd0);
    cfg_write(2, 0, 8'h3C, 8'd27, 1'b0); check("R5 slot 2 keeps", 2'd0);
    cfg_write(6, 5, 8'h3C, 8'd27, 1'b0); check("R5 slot 6 keeps", 2'd0);
    cfg_write(1, 0, 8'h3C, 8'd27, 1'b0); check("R5 slot 1 broken", 2'd1);
    apply_reset(2'd0);
    cfg_write(0, 0, 8'h3C, 8'd27, 1'b0); check("R5 slot 0 broken", 2'd1);
  endtask

  task automatic t_swizzle;
    apply_reset(2'd0);
    cfg_write(5, 0, 8'h3C, 8'd28, 1'b0); check("R6 slot 5 value 28", 2'd1);
    apply_reset(2'd0);
    cfg_write(3, 0, 8'h3C, 8'd94, 1'b0); check("R6 slot 3 value 94", 2'd1);
    apply_reset(2'd0);
    cfg_write(0, 0, 8'h3C, 8'd91, 1'b0); check("R6 slot 0 value 91", 2'd1);
    apply_reset(2'd0);
    cfg_write(2, 0, 8'h3C, 8'd29, 1'b0); check("R6 slot 2 value 29", 2'd1);
  endtask

  task automatic t_force_ok;
    apply_reset(2'd0);
    cfg_write(2, 0, 8'h3C, 8'd30, 1'b0); check("R7 slot 2 value 30", 2'd2);
    apply_reset(2'd0);
    cfg_write(0, 0, 8'h3C, 8'd92, 1'b0); check("R7 slot 0 value 92", 2'd2);
  endtask

  task automatic t_slot_field;
    apply_reset(2'd0);
    cfg_write(9, 7, 8'h3C, 8'd28, 1'b0); check("R4 slot 9 mod 1 broken", 2'd1);
    apply_reset(2'd0);
    cfg_write(4, 1, 8'h3C, 8'd28, 1'b0); check("R4 slot 4 mod 0 value 28", 2'd2);
  endtask

  task automatic t_lock;
    apply_reset(2'd1);
    cfg_write(1, 0, 8'h3C, 8'd100, 1'b0); check("R2 broken stays", 2'd1);
    apply_reset(2'd0);
    cfg_write(3, 0, 8'h3C, 8'd5, 1'b0);   check("R2 becomes force-ok", 2'd2);
    cfg_write(1, 0, 8'h3C, 8'd27, 1'b0);  check("R2 force-ok stays", 2'd2);
  endtask

  task automatic t_timing;
    apply_reset(2'd0);
    @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wdata = 8'd28; cfg_addr = {8'h00, 5'd1, 3'd0, 8'h3C};
    #2;
    check("R8 unchanged before edge", 2'd0);
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    check("R8 updated after edge", 2'd1);
  endtask

  initial begin
    t_presets();
    t_qualify();
    t_base_value();
    t_swizzle();
    t_force_ok();
    t_slot_field();
    t_lock();
    t_timing();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run incomplete actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule